// File: doc/BRIEF.md
# Dual Nibble Stack Engine

This block carries out the stack transfer instructions of a 4-bit processor core that keeps two independent stacks in one nibble-wide data memory. The nibble stack, addressed by an 8-bit pointer, holds single 4-bit values for the accumulator pair A and B and for the flag register F. The word stack, addressed by a second 8-bit pointer, holds 16-bit entries for the index registers X and Y. The word pointer counts whole entries, and each entry takes four consecutive nibble addresses, so the word pointer is scaled by four before it reaches memory.

The core hands the block a 13-bit instruction word with a valid strobe. A nibble transfer finishes in the cycle it is accepted. A word transfer is spread over four memory beats on consecutive cycles, starting in the accepted cycle. A busy flag covers the three trailing beats, and the block ignores any instruction offered while busy is high. The memory read path is combinational: read data belongs to the address driven in the same cycle. Writes take effect at the clock edge. Register contents and both pointers are exposed so that the core can use them, for example when it branches or returns through the word pointer.

Top module: `dual_stack_engine`

## Requirements
- R1: The block accepts an instruction only when valid is high, busy is low, bits 12..5 are all ones and bit 4 is zero. Bit 3 selects pop (1) or push (0). Bits 2..0 select the register: 111 is A, 110 is B, 101 is F, 001 is X and 01x is Y. Any other word causes no memory strobe and changes no register and no pointer.
- R2: Pushing A, B or F drives the address nibPtr−1 with a write strobe and the register value in the accepted cycle. nibPtr holds that decremented value after the edge, and busy stays low.
- R3: Popping A, B or F drives the address nibPtr with a read strobe in the accepted cycle. The register takes the read nibble, and nibPtr is one higher after the edge.
- R4: F moves as a whole nibble, with the flags E, I, C and Z in bits 3 down to 0. All 16 values survive a pop followed by a push.
- R5: A push of X or Y writes bits 4k+3..4k of the register to nibble address (wordPtr−1)×4+k in beat k, for k = 0..3, on four consecutive cycles. wordPtr is one lower after the last beat.
- R6: A pop of X or Y reads nibble address wordPtr×4+k in beat k into bits 4k+3..4k of the register. wordPtr is one higher after the last beat.
- R7: busy is low in the accepted cycle of a word transfer and high for exactly the three cycles that follow. Every cycle with busy high carries a memory strobe, and any instruction offered while busy is high is ignored.
- R8: The two Y codes, 010 and 011, behave identically.
- R9: Both pointers wrap modulo 256. A push at pointer 0 uses nibble address 255 for the nibble stack and addresses 1020..1023 for the word stack.
- R10: While synchronous reset is held, both pointers and all five registers become zero, and busy and both memory strobes are low once it is released.
- R11: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word is offered this cycle |
| instrWord | input | 13 | Instruction word |
| busy | output | 1 | Trailing beats of a word transfer in progress |
| memAddr | output | 10 | Nibble address into data memory |
| memWrEn | output | 1 | Write strobe |
| memWrData | output | 4 | Nibble to write |
| memRdEn | output | 1 | Read strobe |
| memRdData | input | 4 | Nibble read at memAddr, same cycle |
| regA | output | 4 | Register A |
| regB | output | 4 | Register B |
| regF | output | 4 | Flag register (E, I, C, Z in bits 3..0) |
| regX | output | 16 | Index register X |
| regY | output | 16 | Index register Y |
| nibPtr | output | 8 | Nibble stack pointer |
| wordPtr | output | 8 | Word stack pointer |

## Verification
The bench builds the block with its default widths: 4-bit nibbles, 16-bit words and 8-bit pointers. With these widths the whole 1024-nibble memory can be modelled in the bench, and both wrap points are reached from the reset value of the pointers. Every one of the 16 nibble values goes through A, B and F, first popped and then pushed back. Sixteen arithmetically generated words go through X and through both Y codes, with the address of each beat compared in its own cycle. Instructions offered during busy cycles and words that fail decoding are checked at the pointers, the registers and the memory strobes.

// File: rtl/stack_pkg.sv
package stack_pkg;

  localparam int INSTR_W = 13;
  localparam logic [7:0] OP_PREFIX = 8'hFF;

  typedef enum logic [2:0] {
    SEL_A = 3'd0,
    SEL_B = 3'd1,
    SEL_F = 3'd2,
    SEL_X = 3'd3,
    SEL_Y = 3'd4
  } regSel_e;

  typedef struct packed {
    logic    nibOp;     // single-nibble transfer this cycle
    logic    wordOp;    // one beat of a word transfer this cycle
    logic    isPop;     // direction: 1 = memory to register
    logic    lastBeat;  // final beat of a word transfer
    regSel_e sel;       // register involved
  } stackCtl_t;

endpackage

// File: rtl/stack_control.sv
module stack_control
  import stack_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output stackCtl_t          ctl,
  output logic [BEAT_W-1:0]  beat,
  output logic               busy
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic        prefixOk;
  logic        legal;
  regSel_e     decSel;
  logic        decWord;
  logic        accept;

  logic              busyQ;
  logic [BEAT_W-1:0] beatQ;
  logic              popQ;
  regSel_e           selQ;

  assign prefixOk = (instrWord[12:5] == OP_PREFIX) && !instrWord[4];

  always_comb begin
    legal  = 1'b1;
    decSel = SEL_A;
    unique case (instrWord[2:0])
      3'b111:         decSel = SEL_A;
      3'b110:         decSel = SEL_B;
      3'b101:         decSel = SEL_F;
      3'b001:         decSel = SEL_X;
      3'b010, 3'b011: decSel = SEL_Y;
      default: begin
        decSel = SEL_A;
        legal  = 1'b0;
      end
    endcase
  end

  assign decWord = (decSel == SEL_X) || (decSel == SEL_Y);
  assign accept  = instrValid && !busyQ && prefixOk && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ <= 1'b0;
      beatQ <= '0;
      popQ  <= 1'b0;
      selQ  <= SEL_X;
    end else if (accept && decWord) begin
      busyQ <= 1'b1;
      beatQ <= BEAT_W'(1);
      popQ  <= instrWord[3];
      selQ  <= decSel;
    end else if (busyQ) begin
      if (beatQ == LAST_BEAT) begin
        busyQ <= 1'b0;
        beatQ <= '0;
      end else begin
        beatQ <= beatQ + BEAT_W'(1);
      end
    end
  end

  always_comb begin
    beat         = busyQ ? beatQ : '0;
    ctl.nibOp    = accept && !decWord;
    ctl.wordOp   = busyQ || (accept && decWord);
    ctl.isPop    = busyQ ? popQ : instrWord[3];
    ctl.sel      = busyQ ? selQ : decSel;
    ctl.lastBeat = ctl.wordOp && (beat == LAST_BEAT);
  end

  assign busy = busyQ;

endmodule

// File: rtl/stack_datapath.sv
module stack_datapath
  import stack_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int WORD_W = 16,
  parameter int SP_W   = 8,
  localparam int BEATS  = WORD_W / NIB_W,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int ADDR_W = SP_W + BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  stackCtl_t         ctl,
  input  logic [BEAT_W-1:0] beat,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [NIB_W-1:0]  memWrData,
  output logic              memRdEn,
  input  logic [NIB_W-1:0]  memRdData,
  output logic [NIB_W-1:0]  regA,
  output logic [NIB_W-1:0]  regB,
  output logic [NIB_W-1:0]  regF,
  output logic [WORD_W-1:0] regX,
  output logic [WORD_W-1:0] regY,
  output logic [SP_W-1:0]   nibPtr,
  output logic [SP_W-1:0]   wordPtr
);

  localparam logic [SP_W-1:0] PTR_ONE = SP_W'(1);

  logic [NIB_W-1:0]  nibOut;
  logic [WORD_W-1:0] wordOut;
  logic [SP_W-1:0]   nibTop;
  logic [SP_W-1:0]   wordTop;
  logic              anyOp;

  assign anyOp   = ctl.nibOp || ctl.wordOp;
  assign nibTop  = ctl.isPop ? nibPtr : (nibPtr - PTR_ONE);
  assign wordTop = ctl.isPop ? wordPtr : (wordPtr - PTR_ONE);

  always_comb begin
    unique case (ctl.sel)
      SEL_B:   nibOut = regB;
      SEL_F:   nibOut = regF;
      default: nibOut = regA;
    endcase
    wordOut = (ctl.sel == SEL_Y) ? regY : regX;
  end

  always_comb begin
    if (ctl.wordOp) begin
      memAddr   = {wordTop, beat};
      memWrData = wordOut[beat*NIB_W +: NIB_W];
    end else begin
      memAddr   = ADDR_W'(nibTop);
      memWrData = nibOut;
    end
    memWrEn = anyOp && !ctl.isPop;
    memRdEn = anyOp && ctl.isPop;
  end

  // pointer registers
  always_ff @(posedge clk) begin
    if (rst) begin
      nibPtr  <= '0;
      wordPtr <= '0;
    end else begin
      if (ctl.nibOp) begin
        nibPtr <= ctl.isPop ? (nibPtr + PTR_ONE) : (nibPtr - PTR_ONE);
      end
      if (ctl.lastBeat) begin
        wordPtr <= ctl.isPop ? (wordPtr + PTR_ONE) : (wordPtr - PTR_ONE);
      end
    end
  end

  // register file: nibble registers
  always_ff @(posedge clk) begin
    if (rst) begin
      regA <= '0;
      regB <= '0;
      regF <= '0;
    end else if (ctl.nibOp && ctl.isPop) begin
      unique case (ctl.sel)
        SEL_B:   regB <= memRdData;
        SEL_F:   regF <= memRdData;
        default: regA <= memRdData;
      endcase
    end
  end

  // register file: word registers, filled one nibble per beat
  always_ff @(posedge clk) begin
    if (rst) begin
      regX <= '0;
      regY <= '0;
    end else if (ctl.wordOp && ctl.isPop) begin
      if (ctl.sel == SEL_Y) begin
        regY[beat*NIB_W +: NIB_W] <= memRdData;
      end else begin
        regX[beat*NIB_W +: NIB_W] <= memRdData;
      end
    end
  end

endmodule

// File: rtl/dual_stack_engine.sv
module dual_stack_engine
  import stack_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int WORD_W = 16,
  parameter int SP_W   = 8,
  localparam int BEATS  = WORD_W / NIB_W,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int ADDR_W = SP_W + BEAT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output logic               busy,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memWrEn,
  output logic [NIB_W-1:0]   memWrData,
  output logic               memRdEn,
  input  logic [NIB_W-1:0]   memRdData,
  output logic [NIB_W-1:0]   regA,
  output logic [NIB_W-1:0]   regB,
  output logic [NIB_W-1:0]   regF,
  output logic [WORD_W-1:0]  regX,
  output logic [WORD_W-1:0]  regY,
  output logic [SP_W-1:0]    nibPtr,
  output logic [SP_W-1:0]    wordPtr
);

  stackCtl_t         ctl;
  logic [BEAT_W-1:0] beat;

  stack_control #(.BEATS(BEATS)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .instrValid(instrValid),
    .instrWord (instrWord),
    .ctl       (ctl),
    .beat      (beat),
    .busy      (busy)
  );

  stack_datapath #(.NIB_W(NIB_W), .WORD_W(WORD_W), .SP_W(SP_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .beat     (beat),
    .memAddr  (memAddr),
    .memWrEn  (memWrEn),
    .memWrData(memWrData),
    .memRdEn  (memRdEn),
    .memRdData(memRdData),
    .regA     (regA),
    .regB     (regB),
    .regF     (regF),
    .regX     (regX),
    .regY     (regY),
    .nibPtr   (nibPtr),
    .wordPtr  (wordPtr)
  );

endmodule

// File: rtl/stack_checks.sv
module stack_checks #(
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            instrValid,
  input logic [12:0]     instrWord,
  input logic            busy,
  input logic            memWrEn,
  input logic            memRdEn,
  input logic [SP_W-1:0] nibPtr,
  input logic [SP_W-1:0] wordPtr
);

  localparam logic [12:0] PUSH_A = 13'b1111111100111;

  // R11: never read and write together
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(memWrEn && memRdEn));

  // R2: accepted push of A lowers the nibble pointer by one
  p_nib_push_step_r2: assert property (@(posedge clk) disable iff (rst)
    (instrValid && !busy && instrWord == PUSH_A)
      |=> nibPtr == $past(nibPtr) - SP_W'(1));

  // R7: every busy cycle carries a memory beat
  p_busy_beat_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (memWrEn || memRdEn));

  // R7: nothing offered during busy reaches the nibble stack
  p_busy_holds_nib_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(nibPtr));

  // R5/R6: the word pointer moves once the last beat has finished
  p_word_ptr_moves_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> wordPtr != $past(wordPtr));

  // R1: a word without the shared prefix never strobes memory when idle
  p_bad_prefix_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && (instrWord[12:5] != 8'hFF || instrWord[4]))
      |-> !(memWrEn || memRdEn));

endmodule

bind dual_stack_engine stack_checks #(.SP_W(SP_W)) u_stack_checks (
  .clk       (clk),
  .rst       (rst),
  .instrValid(instrValid),
  .instrWord (instrWord),
  .busy      (busy),
  .memWrEn   (memWrEn),
  .memRdEn   (memRdEn),
  .nibPtr    (nibPtr),
  .wordPtr   (wordPtr)
);

// File: tb/tb_dual_stack_engine.sv
module tb_dual_stack_engine;

  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [12:0] instrWord = '0;
  logic        busy;
  logic [9:0]  memAddr;
  logic        memWrEn;
  logic [3:0]  memWrData;
  logic        memRdEn;
  logic [3:0]  memRdData;
  logic [3:0]  regA, regB, regF;
  logic [15:0] regX, regY;
  logic [7:0]  nibPtr, wordPtr;

  logic [3:0] mem [0:1023];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0]  eSp1 = 8'd0;
  logic [7:0]  eSp2 = 8'd0;
  logic [3:0]  eA = 0, eB = 0, eF = 0;
  logic [15:0] eX = 0, eY = 0;

  always #(CLK_NS/2) clk = ~clk;

  dual_stack_engine dut (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .busy(busy), .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdEn(memRdEn), .memRdData(memRdData), .regA(regA), .regB(regB),
    .regF(regF), .regX(regX), .regY(regY), .nibPtr(nibPtr), .wordPtr(wordPtr)
  );

  assign memRdData = mem[memAddr];
  always @(posedge clk) if (memWrEn) mem[memAddr] <= memWrData;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] opWord(input bit pop, input logic [2:0] code);
    return {8'hFF, 1'b0, pop, code};
  endfunction

  function automatic logic [3:0] nibReg(input logic [2:0] code);
    case (code)
      3'b110:  return regB;
      3'b101:  return regF;
      default: return regA;
    endcase
  endfunction

  function automatic logic [3:0] nibModel(input logic [2:0] code);
    case (code)
      3'b110:  return eB;
      3'b101:  return eF;
      default: return eA;
    endcase
  endfunction

  // nibble pop of value v, then push back; code 111/110/101
  task automatic nibRound(input logic [2:0] code, input logic [3:0] v, input string req);
    logic [9:0] a;
    a = {2'b00, eSp2};
    mem[a] = v;
    instrValid = 1'b1; instrWord = opWord(1'b1, code);
    #1;
    chk({req, " R3 pop addr"}, 32'(memAddr), 32'(a));
    chk({req, " R3 pop rd strobe"}, 32'({memRdEn, memWrEn}), 32'b10);
    @(negedge clk); instrValid = 1'b0;
    case (code) 3'b110: eB = v; 3'b101: eF = v; default: eA = v; endcase
    eSp2 = eSp2 + 8'd1;
    chk({req, " R3 pop value"}, 32'(nibReg(code)), 32'(v));
    chk({req, " R3 pop ptr"}, 32'(nibPtr), 32'(eSp2));
    // push back
    a = {2'b00, eSp2 - 8'd1};
    mem[a] = ~v;
    instrValid = 1'b1; instrWord = opWord(1'b0, code);
    #1;
    chk({req, " R2 push addr"}, 32'(memAddr), 32'(a));
    chk({req, " R2 push busy"}, 32'(busy), 32'd0);
    @(negedge clk); instrValid = 1'b0;
    eSp2 = eSp2 - 8'd1;
    chk({req, " R2 push mem"}, 32'(mem[a]), 32'(nibModel(code)));
    chk({req, " R2 push ptr"}, 32'(nibPtr), 32'(eSp2));
  endtask

  // word transfer; checks every beat
  task automatic wordOp(input bit pop, input logic [2:0] code, input logic [15:0] v);
    logic [9:0] base;
    bit isY;
    isY  = (code[2:1] == 2'b01);
    base = pop ? {eSp1, 2'b00} : {eSp1 - 8'd1, 2'b00};
    if (pop) for (int k = 0; k < 4; k++) mem[base + 10'(k)] = v[k*4 +: 4];
    else     for (int k = 0; k < 4; k++) mem[base + 10'(k)] = 4'hF ^ 4'(k);
    instrValid = 1'b1; instrWord = opWord(pop, code);
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(pop ? "R6 beat addr" : "R5 beat addr", 32'(memAddr), 32'(base + 10'(k)));
      chk("R7 busy per beat", 32'(busy), (k == 0) ? 32'd0 : 32'd1);
      @(negedge clk); instrValid = 1'b0;
    end
    if (pop) begin
      eSp1 = eSp1 + 8'd1;
      if (isY) eY = v; else eX = v;
      chk(isY ? "R6 R8 pop Y value" : "R6 pop X value", 32'(isY ? regY : regX), 32'(v));
      chk("R6 pop ptr", 32'(wordPtr), 32'(eSp1));
    end else begin
      eSp1 = eSp1 - 8'd1;
      for (int k = 0; k < 4; k++)
        chk(isY ? "R5 R8 push Y nibble" : "R5 push X nibble", 32'(mem[base + 10'(k)]),
            32'((isY ? eY : eX) >> (4*k)) & 32'hF);
      chk("R5 push ptr", 32'(wordPtr), 32'(eSp1));
    end
    chk("R7 busy clear", 32'(busy), 32'd0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: reset state
    chk("R10 pointers", 32'({nibPtr, wordPtr}), 32'd0);
    chk("R10 nibble regs", 32'({regA, regB, regF}), 32'd0);
    chk("R10 word regs", {regX, regY}, 32'd0);
    chk("R10 idle outputs", 32'({busy, memWrEn, memRdEn}), 32'd0);
    @(negedge clk);

    // R9: wrap of both pointers on push from zero
    mem[255] = 4'h9;
    instrValid = 1'b1; instrWord = opWord(1'b0, 3'b111);
    #1;
    chk("R9 nib wrap addr", 32'(memAddr), 32'd255);
    @(negedge clk); instrValid = 1'b0;
    eSp2 = 8'd255;
    chk("R9 nib wrap ptr", 32'(nibPtr), 32'd255);
    chk("R9 nib wrap mem", 32'(mem[255]), 32'd0);
    wordOp(1'b0, 3'b001, 16'h0);   // addresses 1020..1023
    chk("R9 word wrap ptr", 32'(wordPtr), 32'd255);
    wordOp(1'b1, 3'b001, 16'hBEEF);
    chk("R9 word ptr back", 32'(wordPtr), 32'd0);

    // R2 R3 R4: all nibble values through A, B, F
    for (int v = 0; v < 16; v++) begin
      nibRound(3'b111, 4'(v), "A");
      nibRound(3'b110, 4'(v), "B");
      nibRound(3'b101, 4'(v), "R4 F");
      // move the nibble pointer so addresses differ per value
      mem[{2'b00, eSp2}] = 4'(v);
      instrValid = 1'b1; instrWord = opWord(1'b1, 3'b111);
      @(negedge clk); instrValid = 1'b0;
      eSp2 = eSp2 + 8'd1; eA = 4'(v);
    end
    chk("R3 pointer walk", 32'(nibPtr), 32'(eSp2));

    // R5 R6 R8: word sweep through X and both Y codes
    for (int i = 0; i < 16; i++) begin
      logic [15:0] w;
      w = 16'(i * 16'h9E37 + 16'h0F1E);
      wordOp(1'b1, 3'b001, w);
      wordOp(1'b0, 3'b001, 16'h0);
      wordOp(1'b1, 3'b010, ~w);
      wordOp(1'b0, 3'b011, 16'h0);
      wordOp(1'b1, 3'b011, w ^ 16'h5A5A);
      wordOp(1'b0, 3'b010, 16'h0);
      wordOp(1'b1, 3'b001, w);   // leave pointer moving upward
    end

    // R7: instructions held during busy are ignored
    mem[{eSp1, 2'b00}] = 4'h1; mem[{eSp1, 2'b01}] = 4'h2;
    mem[{eSp1, 2'b10}] = 4'h3; mem[{eSp1, 2'b11}] = 4'h4;
    instrValid = 1'b1; instrWord = opWord(1'b1, 3'b001);
    @(negedge clk);
    instrWord = opWord(1'b0, 3'b111);
    repeat (3) @(negedge clk);
    instrValid = 1'b0;
    eSp1 = eSp1 + 8'd1; eX = 16'h4321;
    chk("R7 nib ptr untouched during busy", 32'(nibPtr), 32'(eSp2));
    chk("R7 pop completes", 32'(regX), 32'h4321);
    chk("R7 word ptr", 32'(wordPtr), 32'(eSp1));

    // R1: words that fail decoding
    begin
      logic [12:0] bad [4];
      bad[0] = {8'hFF, 1'b1, 1'b0, 3'b111};
      bad[1] = {8'hFF, 1'b0, 1'b0, 3'b000};
      bad[2] = {8'hFF, 1'b0, 1'b1, 3'b100};
      bad[3] = {8'hFE, 1'b0, 1'b0, 3'b111};
      for (int j = 0; j < 4; j++) begin
        instrValid = 1'b1; instrWord = bad[j];
        #1;
        chk("R1 no strobe", 32'({memWrEn, memRdEn, busy}), 32'd0);
        @(negedge clk); instrValid = 1'b0;
        chk("R1 pointers kept", 32'({nibPtr, wordPtr}), 32'({eSp2, eSp1}));
        chk("R1 nibble regs kept", 32'({regA, regB, regF}), 32'({eA, eB, eF}));
        chk("R1 word regs kept", {regX, regY}, {eX, eY});
      end
    end

    // R11: idle cycle after all traffic
    #1;
    chk("R11 strobes idle", 32'({memWrEn, memRdEn}), 32'd0);
    @(negedge clk);
    finishRun();
  end

endmodule